// File: doc/BRIEF.md
# Sequential Shared-Multiplier Complex Multiplier

This block multiplies two complex numbers, x = a + jb and y = c + jd, and returns the real part ac − bd and the imaginary part ad + bc. Each input part is a signed fixed-point value with 4 integer bits and 12 fraction bits, 16 bits in all. Each result part is a signed fixed-point value with 8 integer bits and 24 fraction bits, 32 bits in all. Area is the goal, so the block has only one signed 16×16 multiplier and one add/subtract unit. A small control state machine steps them through four partial products.

A user drives the four operand parts and pulses `start` while the block is idle. The operands are captured on that edge and inputs may change freely afterwards. Four clock cycles later `done` is high for one cycle with both result parts valid. The results then stay put until the next accepted start.

Top module: `cmul_seq`

## Requirements
- R1: Inputs are signed 4.12 values and outputs are signed 8.24 values. Every 16×16 signed product is kept at its full 32-bit width and is used without any shift, so an input of 1.0 (0x1000) times 1.0 gives 0x0100_0000.
- R2: The real result `prod_re` equals a·c − b·d, reduced modulo 2^32 as a two's-complement value (a=`op_a_re`, b=`op_a_im`, c=`op_b_re`, d=`op_b_im`).
- R3: The imaginary result `prod_im` equals a·d + b·c modulo 2^32. The single case that overflows wraps: with all four inputs at 0x8000 (−8.0), the exact imaginary value +128.0 appears as 0x8000_0000 and the real part is 0.
- R4: The operands are captured on the clock edge where `start` is sampled high in the idle state. Changes to the operand inputs after that edge have no effect on the result.
- R5: A high `start` during a computation is ignored. It causes no extra `done` pulse, and the results of the running computation are unchanged.
- R6: If `start` is accepted at edge E0, `done` is high for exactly one cycle, which is the cycle that follows edge E4.
- R7: After `done`, both outputs hold their values until the first edge after the next accepted start.
- R8: A synchronous active-high `rst` returns the controller to idle, clears `done` and clears both outputs to zero.
- R9: The partial products are formed in a fixed order. After E1 `prod_re` shows a·c. After E2 it shows a·c − b·d. After E3 `prod_im` shows a·d. After E4 it shows a·d + b·c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| op_a_re | input | 16 | Real part a of first operand, signed 4.12 |
| op_a_im | input | 16 | Imaginary part b of first operand, signed 4.12 |
| op_b_re | input | 16 | Real part c of second operand, signed 4.12 |
| op_b_im | input | 16 | Imaginary part d of second operand, signed 4.12 |
| prod_re | output | 32 | Real result, signed 8.24 |
| prod_im | output | 32 | Imaginary result, signed 8.24 |
| done | output | 1 | One-cycle flag that results are valid |

## Verification
The accumulators drive the outputs directly, so a wrong step in the schedule becomes visible within one cycle. A wrong operand pairing or a wrong add/subtract sign changes `prod_re` after E1 or E2, and `prod_im` after E3 or E4. A controller that leaves idle on a start it should ignore, or that stays busy too long, shows up as a `done` pulse in the wrong cycle or a second one. Operands that are not held in their capture register show up in the final results once the inputs are scrambled after start. The wrap case exposes any widened or saturating accumulator at the final `done`.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    localparam int unsigned OPW = 16;
    localparam int unsigned PRW = 2 * OPW;

    typedef logic signed [OPW-1:0] opnd_t;
    typedef logic signed [PRW-1:0] prod_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AC,
        ST_BD,
        ST_AD,
        ST_BC
    } state_e;

    typedef enum logic [1:0] {
        MO_AC,
        MO_BD,
        MO_AD,
        MO_BC
    } mop_e;

    typedef struct packed {
        logic en;
        mop_e op;
    } step_t;

    typedef struct packed {
        opnd_t xr;
        opnd_t xi;
        opnd_t yr;
        opnd_t yi;
    } cpair_t;

    function automatic logic step_subtracts(mop_e op);
        return op == MO_BD;
    endfunction

    function automatic logic step_loads(mop_e op);
        return (op == MO_AC) || (op == MO_AD);
    endfunction

    function automatic logic step_to_im(mop_e op);
        return (op == MO_AD) || (op == MO_BC);
    endfunction

endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
    import cmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  capture,
    output step_t step,
    output logic  done
);

    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_AC;
            ST_AC:   state_d = ST_BD;
            ST_BD:   state_d = ST_AD;
            ST_AD:   state_d = ST_BC;
            ST_BC:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step.en = (state_q != ST_IDLE);
        unique case (state_q)
            ST_BD:   step.op = MO_BD;
            ST_AD:   step.op = MO_AD;
            ST_BC:   step.op = MO_BC;
            default: step.op = MO_AC;
        endcase
    end

    assign capture = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_BC);
        end
    end

endmodule

// File: rtl/cmul_opreg.sv
module cmul_opreg
    import cmul_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  cpair_t ops_in,
    output cpair_t ops_q
);

    always_ff @(posedge clk) begin
        if (rst)          ops_q <= '0;
        else if (capture) ops_q <= ops_in;
    end

endmodule

// File: rtl/cmul_mac.sv
module cmul_mac
    import cmul_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cpair_t ops,
    input  step_t  step,
    output prod_t  acc_re,
    output prod_t  acc_im
);

    opnd_t mul_x, mul_y;
    prod_t prod, base, sum;

    // Operand selection for the single shared multiplier
    always_comb begin
        unique case (step.op)
            MO_AC:   begin mul_x = ops.xr; mul_y = ops.yr; end
            MO_BD:   begin mul_x = ops.xi; mul_y = ops.yi; end
            MO_AD:   begin mul_x = ops.xr; mul_y = ops.yi; end
            default: begin mul_x = ops.xi; mul_y = ops.yr; end
        endcase
    end

    // Full-width signed product: 4.12 x 4.12 is already 8.24
    assign prod = prod_t'(mul_x) * prod_t'(mul_y);

    // Single add/subtract unit shared by both accumulators
    always_comb begin
        if (step_loads(step.op))      base = '0;
        else if (step_to_im(step.op)) base = acc_im;
        else                          base = acc_re;
        sum = step_subtracts(step.op) ? (base - prod) : (base + prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (step.en) begin
            if (step_to_im(step.op)) acc_im <= sum;
            else                     acc_re <= sum;
        end
    end

endmodule

// File: rtl/cmul_seq.sv
module cmul_seq
    import cmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPW-1:0]    op_a_re,
    input  logic [OPW-1:0]    op_a_im,
    input  logic [OPW-1:0]    op_b_re,
    input  logic [OPW-1:0]    op_b_im,
    output logic [PRW-1:0]    prod_re,
    output logic [PRW-1:0]    prod_im,
    output logic              done
);

    logic   capture;
    logic   busy;
    step_t  step;
    cpair_t ops_in, ops_q;
    prod_t  acc_re, acc_im;

    assign ops_in = '{xr: op_a_re, xi: op_a_im, yr: op_b_re, yi: op_b_im};
    assign busy   = step.en;

    cmul_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .capture (capture),
        .step    (step),
        .done    (done)
    );

    cmul_opreg u_opreg (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .ops_in  (ops_in),
        .ops_q   (ops_q)
    );

    cmul_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .ops    (ops_q),
        .step   (step),
        .acc_re (acc_re),
        .acc_im (acc_im)
    );

    assign prod_re = acc_re;
    assign prod_im = acc_im;

endmodule

// File: rtl/cmul_seq_chk.sv
module cmul_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        done,
    input logic        busy,
    input logic [31:0] re_o,
    input logic [31:0] im_o
);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 5));

    a_r7_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(re_o) && $stable(im_o)));

    a_r5_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r5_busy_four: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && !busy && re_o == 32'd0 && im_o == 32'd0));

endmodule

bind cmul_seq cmul_seq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done),
    .busy  (busy),
    .re_o  (prod_re),
    .im_o  (prod_im)
);

// File: tb/cmul_seq_test.sv
module cmul_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] a = '0, b = '0, c = '0, d = '0;
    logic [31:0] prod_re, prod_im;
    logic        done;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cmul_seq uut (
        .clk(clk), .rst(rst), .start(start),
        .op_a_re(a), .op_a_im(b), .op_b_re(c), .op_b_im(d),
        .prod_re(prod_re), .prod_im(prod_im), .done(done)
    );

    function automatic logic [31:0] want_re(logic [15:0] x, y, u, v);
        longint p = longint'($signed(x)) * longint'($signed(u))
                  - longint'($signed(y)) * longint'($signed(v));
        return p[31:0];
    endfunction

    function automatic logic [31:0] want_im(logic [15:0] x, y, u, v);
        longint p = longint'($signed(x)) * longint'($signed(v))
                  + longint'($signed(y)) * longint'($signed(u));
        return p[31:0];
    endfunction

    function automatic logic [31:0] mul1(logic [15:0] x, logic [15:0] u);
        longint p = longint'($signed(x)) * longint'($signed(u));
        return p[31:0];
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // noisy: hold start high while busy (R5); mid: check schedule order (R9)
    task automatic run_op(input logic [15:0] ia, ib, ic, id,
                          input bit noisy, input bit mid);
        logic [31:0] er = want_re(ia, ib, ic, id);
        logic [31:0] ei = want_im(ia, ib, ic, id);
        @(negedge clk);
        a = ia; b = ib; c = ic; d = id; start = 1'b1;
        @(negedge clk);                   // after E0
        start = noisy;
        a = $urandom; b = $urandom; c = $urandom; d = $urandom;   // R4 scramble
        check(done == 1'b0, "R6 no early done", 32'(done), 32'd0);
        @(negedge clk);                   // after E1
        if (mid) check(prod_re == mul1(ia, ic), "R9 step ac", prod_re, mul1(ia, ic));
        @(negedge clk);                   // after E2
        if (mid) check(prod_re == er, "R9 step bd", prod_re, er);
        @(negedge clk);                   // after E3
        if (mid) check(prod_im == mul1(ia, id), "R9 step ad", prod_im, mul1(ia, id));
        check(done == 1'b0, "R6 no early done", 32'(done), 32'd0);
        start = 1'b0;
        @(negedge clk);                   // after E4
        check(done == 1'b1, "R6 done after E4", 32'(done), 32'd1);
        check(prod_re == er, "R2 real result", prod_re, er);
        check(prod_im == ei, "R3 imag result", prod_im, ei);
        @(negedge clk);
        check(done == 1'b0, "R6 single pulse", 32'(done), 32'd0);
        check(prod_re == er && prod_im == ei, "R7 hold", prod_re, er);
        if (noisy) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check(done == 1'b0, "R5 start ignored no done", 32'(done), 32'd0);
            end
            check(prod_re == er && prod_im == ei, "R5 results unchanged", prod_im, ei);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8 reset done", 32'(done), 32'd0);
        check(prod_re == 32'd0 && prod_im == 32'd0, "R8 reset outputs", prod_re, 32'd0);
        rst = 1'b0;

        // R1: 1.0 * 1.0 -> 0x0100_0000 with no shift
        run_op(16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b1);
        check(prod_re == 32'h0100_0000, "R1 unit format", prod_re, 32'h0100_0000);
        // R1/R2: (0.5 + j0.25)(-2 + j1)
        run_op(16'h0800, 16'h0400, 16'hE000, 16'h1000, 1'b0, 1'b1);
        // R3: wrap of +128.0 on the imaginary part
        run_op(16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b1);
        check(prod_im == 32'h8000_0000, "R3 wrap", prod_im, 32'h8000_0000);
        check(prod_re == 32'h0000_0000, "R3 wrap real zero", prod_re, 32'h0);
        // extremes
        run_op(16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 1'b1, 1'b1);
        run_op(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b1, 1'b0);

        // R8: reset in the middle of a computation
        @(negedge clk);
        a = 16'h1234; b = 16'h4321; c = 16'h0F0F; d = 16'hF0F0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done == 1'b0, "R8 mid reset done", 32'(done), 32'd0);
        check(prod_re == 32'd0 && prod_im == 32'd0, "R8 mid reset outputs", prod_im, 32'd0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(done == 1'b0, "R8 idle after reset", 32'(done), 32'd0);
        end

        // constrained random, some with start held during the run
        for (int n = 0; n < 40; n++) begin
            logic [15:0] ra = $urandom, rb = $urandom, rc = $urandom, rd = $urandom;
            if (n % 7 == 0) ra = 16'h8000;
            if (n % 5 == 0) rd = 16'h7FFF;
            run_op(ra, rb, rc, rd, ($urandom % 3) == 0, ($urandom % 2) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule